// File: doc/BRIEF.md
# Unlock-Sequence Flash Command Decoder

This block sits behind the host bus of a byte-wide flash and turns keyed write sequences into single-cycle operation requests. Every command opens with a two-write unlock key. A third write then picks the operation. It can arm a byte program, where the next write carries the target address and data. It can arm a second key pair whose final write selects chip, sector (4 KB) or block (64 KB) erase. It can also switch the read path into an identification mode or a query mode.

Writes arrive on a synchronous strobe, with address and data valid in the same cycle. A busy input from the status logic freezes the decoder while an internal program or erase runs. The identification and query bytes come back on a read port. A hit flag on that port tells the surrounding logic whether to use this byte or the array byte. The array itself, erase timing and the wider query table live elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, rd_mode is 0 (array read) and no request output is high.
- R2: A sequence starts with AAH written to address 5555H and then 55H written to 2AAAH. Only address bits 14..0 take part in these comparisons; higher bits are ignored.
- R3: After the key, a third write of A0H to 5555H arms programming. The next accepted write, whatever its data (including F0H), raises prog_req for exactly one cycle, starting the cycle after that write. prog_addr and prog_data hold that write's full address and data.
- R4: After the key, 80H to 5555H, AAH to 5555H and 55H to 2AAAH, a sixth write of 10H to 5555H raises chip_erase_req one cycle later.
- R5: The same five writes followed by 30H at any address raise sector_erase_req. sector_addr equals address bits ADDR_W-1..12 of that sixth write.
- R6: The same five writes followed by 50H at any address raise block_erase_req. block_addr equals address bits ADDR_W-1..16 of that sixth write.
- R7: Key plus 90H to 5555H sets rd_mode to 1 (identification). In this mode ident_hit is 1 for every address, ident_data is BFH at address 0, D8H at address 1 when ADDR_W is 20 (D9H when ADDR_W is 21 or more), and 00H elsewhere.
- R8: Key plus 98H to 5555H sets rd_mode to 2 (query). In this mode ident_hit is 1, addresses 10H, 11H and 12H read 51H, 52H and 59H, and other addresses read 00H.
- R9: From any step other than the armed program step, a write of F0H to any address returns rd_mode to 0 and clears the sequence. The key followed by F0H to 5555H has the same effect.
- R10: A write that does not match the expected step clears the sequence and sets rd_mode to 0, so a later A0H does not arm programming without a fresh key.
- R11: While busy is high, writes are ignored entirely: neither the step, the mode nor the request outputs change, exit commands included.
- R12: At most one request output is high in any cycle, and each request lasts one cycle.
- R13: In array read mode (rd_mode 0), ident_hit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Internal program or erase in progress |
| rd_addr | input | ADDR_W | Read address |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query |
| ident_hit | output | 1 | ident_data replaces the array byte |
| ident_data | output | 8 | Identification or query byte |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sector_erase_req | output | 1 | One-cycle sector erase request |
| sector_addr | output | ADDR_W-12 | Sector number |
| block_erase_req | output | 1 | One-cycle block erase request |
| block_addr | output | ADDR_W-16 | Block number |

## Verification
A corrupted step register shows up at the ports on the next write that ends a sequence. Either a request is missing, a request appears without a full key, or a request of the wrong kind appears. In every case the error is visible one cycle after the final write. A wrong mode register shows immediately on rd_mode and on the read port, which is combinational from the mode. Abort and exit faults are therefore caught by reading the port or by trying a truncated sequence right after the offending write. Busy gating is checked by issuing exits and program data under busy and observing unchanged mode and absent requests.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PROG, ST_E3, ST_E4, ST_E5
  } seq_step_e;

  typedef enum logic [1:0] {
    MD_ARRAY = 2'd0,
    MD_IDENT = 2'd1,
    MD_QUERY = 2'd2
  } rd_mode_e;

  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_D1     = 8'hAA;
  localparam logic [7:0]  KEY_D2     = 8'h55;
  localparam logic [7:0]  OP_PROG    = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_ID      = 8'h90;
  localparam logic [7:0]  OP_QUERY   = 8'h98;
  localparam logic [7:0]  OP_EXIT    = 8'hF0;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  OP_SECT    = 8'h30;
  localparam logic [7:0]  OP_BLK     = 8'h50;
  localparam logic [7:0]  MFR_CODE   = 8'hBF;

  // device code depends on array size
  function automatic logic [7:0] dev_code(input int aw);
    return (aw >= 21) ? 8'hD9 : 8'hD8;
  endfunction

  // first bytes of the query table
  function automatic logic [7:0] query_byte(input logic [7:0] off);
    case (off)
      8'h10:   return 8'h51;
      8'h11:   return 8'h52;
      8'h12:   return 8'h59;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_taken,
  input  logic [14:0]     key_addr,
  input  logic [7:0]      wr_data,
  output seq_step_e       step_o,
  output rd_mode_e        mode_o,
  output logic            ev_prog,
  output logic            ev_chip,
  output logic            ev_sect,
  output logic            ev_blk,
  output logic            ev_abort,
  output logic            ev_exit
);

  seq_step_e step_q, step_d;
  rd_mode_e  mode_q, mode_d;
  logic      at_a, at_b;

  assign at_a = (key_addr == KEY_ADDR_A);
  assign at_b = (key_addr == KEY_ADDR_B);

  always_comb begin
    step_d   = step_q;
    mode_d   = mode_q;
    ev_prog  = 1'b0;
    ev_chip  = 1'b0;
    ev_sect  = 1'b0;
    ev_blk   = 1'b0;
    ev_abort = 1'b0;
    ev_exit  = 1'b0;
    if (wr_taken) begin
      if (step_q == ST_PROG) begin
        ev_prog = 1'b1;
        step_d  = ST_IDLE;
      end else if (wr_data == OP_EXIT) begin
        ev_exit = 1'b1;
        step_d  = ST_IDLE;
        mode_d  = MD_ARRAY;
      end else begin
        case (step_q)
          ST_IDLE: if (at_a && wr_data == KEY_D1) step_d = ST_K1;
                   else ev_abort = 1'b1;
          ST_K1:   if (at_b && wr_data == KEY_D2) step_d = ST_K2;
                   else ev_abort = 1'b1;
          ST_K2: begin
            if (!at_a) ev_abort = 1'b1;
            else begin
              case (wr_data)
                OP_PROG:  step_d = ST_PROG;
                OP_ERASE: step_d = ST_E3;
                OP_ID:    begin mode_d = MD_IDENT; step_d = ST_IDLE; end
                OP_QUERY: begin mode_d = MD_QUERY; step_d = ST_IDLE; end
                default:  ev_abort = 1'b1;
              endcase
            end
          end
          ST_E3:   if (at_a && wr_data == KEY_D1) step_d = ST_E4;
                   else ev_abort = 1'b1;
          ST_E4:   if (at_b && wr_data == KEY_D2) step_d = ST_E5;
                   else ev_abort = 1'b1;
          ST_E5: begin
            step_d = ST_IDLE;
            if (wr_data == OP_CHIP && at_a) ev_chip = 1'b1;
            else if (wr_data == OP_SECT)    ev_sect = 1'b1;
            else if (wr_data == OP_BLK)     ev_blk  = 1'b1;
            else                            ev_abort = 1'b1;
          end
          default: ev_abort = 1'b1;
        endcase
        if (ev_abort) begin
          step_d = ST_IDLE;
          mode_d = MD_ARRAY;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      mode_q <= MD_ARRAY;
    end else begin
      step_q <= step_d;
      mode_q <= mode_d;
    end
  end

  assign step_o = step_q;
  assign mode_o = mode_q;

  // R11: no state change without an accepted write
  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_taken |=> $stable(step_q) && $stable(mode_q));

  // R10: mismatch returns to array read with cleared step
  p_abort_to_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (mode_q == MD_ARRAY) && (step_q == ST_IDLE));

  // R9: exit clears mode
  p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_exit |=> (mode_q == MD_ARRAY));

  // R3: armed program step always consumes the next accepted write
  p_prog_consumes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == ST_PROG) && wr_taken |=> (step_q == ST_IDLE));

endmodule

// File: rtl/fcd_req_gen.sv
module fcd_req_gen #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_taken,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ev_prog,
  input  logic              ev_chip,
  input  logic              ev_sect,
  input  logic              ev_blk,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_req,
  output logic              sect_req,
  output logic [ADDR_W-13:0] sect_addr,
  output logic              blk_req,
  output logic [ADDR_W-17:0] blk_addr
);

  localparam int SECT_SH = 12;
  localparam int BLK_SH  = 16;
  localparam int SECT_W  = ADDR_W - SECT_SH;
  localparam int BLK_W   = ADDR_W - BLK_SH;

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SECT_SH];
  endfunction

  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_SH];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_req  <= 1'b0;
      chip_req  <= 1'b0;
      sect_req  <= 1'b0;
      blk_req   <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      sect_addr <= '0;
      blk_addr  <= '0;
    end else begin
      prog_req <= ev_prog;
      chip_req <= ev_chip;
      sect_req <= ev_sect;
      blk_req  <= ev_blk;
      if (ev_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ev_sect) sect_addr <= sector_of(wr_addr);
      if (ev_blk)  blk_addr  <= block_of(wr_addr);
    end
  end

  // R12: requests are exclusive
  p_req_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_req, sect_req, blk_req}));

  // R11: every request traces back to an accepted write
  p_req_from_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req || chip_req || sect_req || blk_req) |-> $past(wr_taken));

  // R12: a request never lasts two cycles
  p_req_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);

  // R5: sector number holds between sector requests
  p_sect_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sect |=> $stable(sect_addr));

endmodule

// File: rtl/fcd_ident_rd.sv
module fcd_ident_rd
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  rd_mode_e          mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              ident_hit,
  output logic [7:0]        ident_data
);

  localparam logic [ADDR_W-1:0] ADDR_MFR = '0;
  localparam logic [ADDR_W-1:0] ADDR_DEV = ADDR_W'(1);

  always_comb begin
    ident_hit  = 1'b0;
    ident_data = 8'h00;
    case (mode)
      MD_IDENT: begin
        ident_hit = 1'b1;
        if (rd_addr == ADDR_MFR)      ident_data = MFR_CODE;
        else if (rd_addr == ADDR_DEV) ident_data = dev_code(ADDR_W);
      end
      MD_QUERY: begin
        ident_hit = 1'b1;
        if (rd_addr[ADDR_W-1:8] == '0) ident_data = query_byte(rd_addr[7:0]);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_mode,
  output logic              ident_hit,
  output logic [7:0]        ident_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic [ADDR_W-13:0] sector_addr,
  output logic              block_erase_req,
  output logic [ADDR_W-17:0] block_addr
);

  logic      wr_taken;
  seq_step_e step;
  rd_mode_e  mode;
  logic      ev_prog, ev_chip, ev_sect, ev_blk, ev_abort, ev_exit;

  assign wr_taken = wr_en && !busy;

  fcd_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_taken (wr_taken),
    .key_addr (wr_addr[14:0]),
    .wr_data  (wr_data),
    .step_o   (step),
    .mode_o   (mode),
    .ev_prog  (ev_prog),
    .ev_chip  (ev_chip),
    .ev_sect  (ev_sect),
    .ev_blk   (ev_blk),
    .ev_abort (ev_abort),
    .ev_exit  (ev_exit)
  );

  fcd_req_gen #(.ADDR_W(ADDR_W)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_taken  (wr_taken),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ev_prog   (ev_prog),
    .ev_chip   (ev_chip),
    .ev_sect   (ev_sect),
    .ev_blk    (ev_blk),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .chip_req  (chip_erase_req),
    .sect_req  (sector_erase_req),
    .sect_addr (sector_addr),
    .blk_req   (block_erase_req),
    .blk_addr  (block_addr)
  );

  fcd_ident_rd #(.ADDR_W(ADDR_W)) u_ident (
    .mode       (mode),
    .rd_addr    (rd_addr),
    .ident_hit  (ident_hit),
    .ident_data (ident_data)
  );

  assign rd_mode = mode;

  // R13: array mode never claims the read port
  p_array_no_hit_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd0) |-> !ident_hit);

  // R10: the step returns to idle after an abort or exit, never left mid-way
  p_idle_after_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_abort || ev_exit) |=> (step == ST_IDLE));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0]    rd_mode;
  logic          ident_hit;
  logic [7:0]    ident_data;
  logic          prog_req;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          chip_erase_req, sector_erase_req, block_erase_req;
  logic [AW-13:0] sector_addr;
  logic [AW-17:0] block_addr;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_addr(rd_addr), .rd_mode(rd_mode), .ident_hit(ident_hit),
    .ident_data(ident_data), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .chip_erase_req(chip_erase_req),
    .sector_erase_req(sector_erase_req), .sector_addr(sector_addr),
    .block_erase_req(block_erase_req), .block_addr(block_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] reqs();
    return {prog_req, chip_erase_req, sector_erase_req, block_erase_req};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [AW-1:0] kaddr(input logic [4:0] hi, input logic [14:0] lo);
    return {hi, lo};
  endfunction

  task automatic unlock(input logic [4:0] hi);
    wr(kaddr(hi, 15'h5555), 8'hAA);
    wr(kaddr(hi, 15'h2AAA), 8'h55);
  endtask

  task automatic erase_cmd(input logic [4:0] hi, input logic [AW-1:0] a, input logic [7:0] op);
    unlock(hi);
    wr(kaddr(hi, 15'h5555), 8'h80);
    wr(kaddr(~hi, 15'h5555), 8'hAA);
    wr(kaddr(~hi, 15'h2AAA), 8'h55);
    wr(a, op);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 mode", rd_mode, 0);
    check("R1 reqs", reqs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 mode after release", rd_mode, 0);
    check("R13 hit in array mode", ident_hit, 0);

    // R3 / R2: program sweep, key addresses with varying high bits
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'(i * 32'h13579 + i * 7);
      d = (i == 3) ? 8'hF0 : 8'(i * 23 + 7);
      unlock(5'(i * 3));
      wr(kaddr(5'(i), 15'h5555), 8'hA0);
      check("R3 no req before data", reqs(), 0);
      wr(a, d);
      check("R3 prog req", reqs(), 4'b1000);
      check("R3 prog addr", prog_addr, a);
      check("R3 prog data", prog_data, d);
      @(negedge clk);
      check("R12 prog single cycle", reqs(), 0);
    end

    // R4 / R5 / R6: erase sweep
    for (int i = 0; i < 9; i++) begin
      logic [AW-1:0] a;
      logic [7:0] op;
      a = AW'(i * 32'h21043 + 32'h1000 * i);
      case (i % 3)
        0: op = 8'h30;
        1: op = 8'h50;
        default: begin op = 8'h10; a = kaddr(5'(i), 15'h5555); end
      endcase
      erase_cmd(5'(i), a, op);
      case (i % 3)
        0: begin
          check("R5 sector req", reqs(), 4'b0010);
          check("R5 sector number", sector_addr, a >> 12);
        end
        1: begin
          check("R6 block req", reqs(), 4'b0001);
          check("R6 block number", block_addr, a >> 16);
        end
        default: check("R4 chip req", reqs(), 4'b0100);
      endcase
      @(negedge clk);
      check("R12 erase single cycle", reqs(), 0);
    end

    // R7: identification mode, address sweep
    unlock(5'h1F);
    wr(kaddr(5'h1F, 15'h5555), 8'h90);
    check("R7 mode", rd_mode, 1);
    for (int a = 0; a < 32; a++) begin
      rd_addr = AW'(a);
      #1;
      check("R7 hit", ident_hit, 1);
      check("R7 data", ident_data, (a == 0) ? 8'hBF : (a == 1) ? 8'hD8 : 8'h00);
    end

    // R11: exit ignored under busy
    busy = 1'b1;
    wr(AW'(20'h12345), 8'hF0);
    busy = 1'b0;
    check("R11 exit ignored when busy", rd_mode, 1);

    // R9: single-write exit
    wr(AW'(20'hABCDE), 8'hF0);
    check("R9 single exit", rd_mode, 0);
    rd_addr = '0;
    #1;
    check("R13 no hit after exit", ident_hit, 0);

    // R8: query mode, address sweep
    unlock(5'h02);
    wr(kaddr(5'h02, 15'h5555), 8'h98);
    check("R8 mode", rd_mode, 2);
    for (int a = 0; a < 32; a++) begin
      rd_addr = AW'(a);
      #1;
      check("R8 hit", ident_hit, 1);
      check("R8 data", ident_data,
            (a == 16) ? 8'h51 : (a == 17) ? 8'h52 : (a == 18) ? 8'h59 : 8'h00);
    end

    // R9: three-write exit
    unlock(5'h00);
    check("R9 mode kept mid key", rd_mode, 2);
    wr(kaddr(5'h00, 15'h5555), 8'hF0);
    check("R9 keyed exit", rd_mode, 0);

    // R10: wrong second key clears step
    wr(kaddr(0, 15'h5555), 8'hAA);
    wr(kaddr(0, 15'h2AAA), 8'h54);
    wr(kaddr(0, 15'h5555), 8'hA0);
    wr(AW'(20'h00777), 8'h3C);
    check("R10 no program after abort", reqs(), 0);

    // R2: wrong low address bit aborts
    wr(kaddr(0, 15'h5555), 8'hAA);
    wr(kaddr(0, 15'h2AAB), 8'h55);
    wr(kaddr(0, 15'h5555), 8'hA0);
    wr(AW'(20'h00777), 8'h3C);
    check("R2 low bits compared", reqs(), 0);

    // R10: mismatch in identification mode returns to array read
    unlock(5'h04);
    wr(kaddr(5'h04, 15'h5555), 8'h90);
    check("R7 re-enter", rd_mode, 1);
    wr(kaddr(0, 15'h5555), 8'hAA);
    wr(AW'(20'h01234), 8'h55);
    check("R10 abort leaves ident mode", rd_mode, 0);

    // R11: program data held back under busy, taken after
    unlock(5'h09);
    wr(kaddr(5'h09, 15'h5555), 8'hA0);
    busy = 1'b1;
    wr(AW'(20'h5A5A5), 8'h66);
    check("R11 no request when busy", reqs(), 0);
    busy = 1'b0;
    wr(AW'(20'h0F0F0), 8'h99);
    check("R11 armed step kept", reqs(), 4'b1000);
    check("R11 prog addr after busy", prog_addr, 20'h0F0F0);
    check("R11 prog data after busy", prog_data, 8'h99);

    // R4: chip op with wrong address aborts
    erase_cmd(5'h01, kaddr(0, 15'h1234), 8'h10);
    check("R4 chip needs 5555", reqs(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule